// File: doc/BRIEF.md
# OR-Branching Microprogram Sequencer

This block steps through a horizontal microprogram held in a read-only control store. Each stored microword has three fields: a block of datapath control bits, a test selector and an explicit successor address. The word being executed is held in a microword register, and its control bits drive the datapath for that cycle.

The successor address is not produced by an incrementer or an adder. The branch logic reads datapath status bits and turns the ones named by the test selector into a small mask of up to four bits. That mask is bitwise-ORed into the low bits of the successor field. Microcode puts every multiway target block at an address whose low bits are zero, so a dispatch on as many as four status bits completes in a single microcycle.

The contents of the control store come in through a packed parameter, so a chip build or a bench can fill it with its own microprogram.

Top module: `orbr_useq`

## Requirements
- R1: While `rst` is high at a rising edge, the register for the current address loads 0 and the control output loads all zeros, whatever `status` holds.
- R2: In the first cycle after `rst` falls, the sequencer fetches and executes the word at address 0.
- R3: `ctrl_o` always equals the control field of the stored word at the address shown on `uaddr_o`. Word layout: bits [AW-1:0] hold the successor field, bits [AW+2:AW] hold the test selector, and the bits above those hold the control field.
- R4: Test selector 0 gives a zero mask. The next address is the successor field unchanged, and status is ignored.
- R5: Test selectors 1, 2, 3 and 4 are two-way tests. They OR status bit 0, 1, 2 or 3, in that order, into address bit 0.
- R6: Test selector 5 ORs `status[1:0]` into address bits [1:0]. Test selector 6 ORs `status[3:2]` into address bits [1:0].
- R7: Test selector 7 ORs `status[7:4]` into address bits [3:0], which gives a sixteen-way dispatch.
- R8: The next address is the OR of the successor field and the mask, never their sum. Every bit set in the successor field stays set, and the bits above bit 3 are copied from the field.
- R9: One microword completes per clock. `status` is sampled at the edge that ends the current word, and that edge also loads the word at the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| status | input | 8 | Datapath condition bits tested by the branch logic |
| ctrl_o | output | CW | Control field of the executing microword |
| uaddr_o | output | AW | Address of the executing microword |

## Verification
The bench builds the block with AW=6 and CW=16, which gives a control store of 64 words. A bench function computes those words so that each control field encodes its own address twice, which lets every step confirm the fetched word against the address it landed on. The small store lets one microprogram pass through every test selector, including all four two-way codes and a sixteen-way dispatch. It also places a successor field with a low bit already set under a four-way test, so that an OR and an add would give different targets.

// File: rtl/orbr_useq.sv
module orbr_useq #(
  parameter int AW = 8,
  parameter int CW = 45,
  parameter int DEPTH = 1 << AW,
  parameter int WW = CW + 3 + AW,
  parameter logic [DEPTH*WW-1:0] CS_INIT = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [7:0]    status,
  output logic [CW-1:0] ctrl_o,
  output logic [AW-1:0] uaddr_o
);

  logic [WW-1:0] store [DEPTH];
  logic [WW-1:0] uword_q;
  logic [AW-1:0] uaddr_q;
  logic [AW-1:0] succ;
  logic [2:0]    tsel;
  logic [3:0]    mask;
  logic [AW-1:0] target;

  for (genvar i = 0; i < DEPTH; i++) begin : g_store
    assign store[i] = CS_INIT[i*WW +: WW];
  end

  assign succ = uword_q[AW-1:0];
  assign tsel = uword_q[AW+2:AW];

  always_comb begin
    case (tsel)
      3'd1:    mask = {3'b000, status[0]};
      3'd2:    mask = {3'b000, status[1]};
      3'd3:    mask = {3'b000, status[2]};
      3'd4:    mask = {3'b000, status[3]};
      3'd5:    mask = {2'b00, status[1:0]};
      3'd6:    mask = {2'b00, status[3:2]};
      3'd7:    mask = status[7:4];
      default: mask = 4'b0000;
    endcase
  end

  assign target = succ | {{(AW-4){1'b0}}, mask};

  always_ff @(posedge clk) begin
    if (rst) begin
      uaddr_q <= '0;
      uword_q <= '0;
    end else begin
      uaddr_q <= target;
      uword_q <= store[target];
    end
  end

  assign ctrl_o  = uword_q[WW-1:AW+3];
  assign uaddr_o = uaddr_q;

endmodule

// File: rtl/orbr_useq_chk.sv
module orbr_useq_chk #(
  parameter int AW = 8,
  parameter int CW = 45
) (
  input logic          clk,
  input logic          rst,
  input logic [7:0]    status,
  input logic [AW-1:0] succ,
  input logic [2:0]    tsel,
  input logic [CW-1:0] ctrl_o,
  input logic [AW-1:0] uaddr_o
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (uaddr_o == '0 && ctrl_o == '0));

  // R4
  jump_target_chk: assert property (@(posedge clk) disable iff (rst)
    (tsel == 3'd0) |=> (uaddr_o == $past(succ)));

  // R5
  two_way_chk: assert property (@(posedge clk) disable iff (rst)
    (tsel >= 3'd1 && tsel <= 3'd4) |=>
      (uaddr_o == ($past(succ) | {{(AW-1){1'b0}}, $past(status[tsel-3'd1])})));

  // R6
  four_way_chk: assert property (@(posedge clk) disable iff (rst)
    (tsel == 3'd5 || tsel == 3'd6) |=>
      (uaddr_o == ($past(succ) | {{(AW-2){1'b0}},
        ($past(tsel) == 3'd5 ? $past(status[1:0]) : $past(status[3:2]))})));

  // R7
  sixteen_way_chk: assert property (@(posedge clk) disable iff (rst)
    (tsel == 3'd7) |=> (uaddr_o == ($past(succ) | {{(AW-4){1'b0}}, $past(status[7:4])})));

  // R8
  or_keep_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((uaddr_o & $past(succ)) == $past(succ)) &&
              (uaddr_o[AW-1:4] == $past(succ[AW-1:4]))));

endmodule

bind orbr_useq orbr_useq_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .status(status), .succ(succ), .tsel(tsel),
  .ctrl_o(ctrl_o), .uaddr_o(uaddr_o)
);

// File: tb/orbr_useq_tb.sv
module orbr_useq_tb;
  localparam int AW = 6;
  localparam int CW = 16;
  localparam int DEPTH = 1 << AW;
  localparam int WW = CW + 3 + AW;
  localparam int NV = 21;

  function automatic logic [CW-1:0] ctrl_of(input int a);
    return {4'hC, 6'(a), 6'(a)};
  endfunction

  function automatic logic [DEPTH*WW-1:0] build_cs();
    logic [DEPTH*WW-1:0] img;
    img = '0;
    for (int a = 0; a < DEPTH; a++) begin
      logic [2:0] t;
      logic [5:0] n;
      t = 3'd0; n = 6'd0;
      if (a == 0) n = 6'd1;
      else if (a == 1) begin t = 3'd5; n = 6'd4; end
      else if (a >= 4 && a <= 7) n = 6'd8;
      else if (a == 8) begin t = 3'd1; n = 6'd10; end
      else if (a == 10 || a == 11) begin t = 3'd7; n = 6'd16; end
      else if (a >= 16 && a <= 31) begin t = 3'd2; n = 6'd32; end
      else if (a == 32) begin t = 3'd3; n = 6'd34; end
      else if (a == 33) begin t = 3'd4; n = 6'd34; end
      else if (a == 34 || a == 35) begin t = 3'd6; n = 6'd36; end
      else if (a == 39) n = 6'd40;
      else if (a == 40) begin t = 3'd5; n = 6'd41; end
      img[a*WW +: WW] = {ctrl_of(a), t, n};
    end
    return img;
  endfunction

  localparam logic [DEPTH*WW-1:0] CS_IMG = build_cs();

  localparam logic [7:0] VST [NV] = '{
    8'h00, 8'h00, 8'h02, 8'h00, 8'h01, 8'h90, 8'h02, 8'h08, 8'h0C, 8'h00,
    8'h03, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h04, 8'h04,
    8'hFF};
  localparam logic [5:0] VEA [NV] = '{
    6'd0, 6'd1, 6'd6, 6'd8, 6'd11, 6'd25, 6'd33, 6'd35, 6'd39, 6'd40,
    6'd43, 6'd0, 6'd1, 6'd4, 6'd8, 6'd10, 6'd16, 6'd32, 6'd35, 6'd37,
    6'd0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] status = 8'h00;
  logic [CW-1:0] ctrl_o;
  logic [AW-1:0] uaddr_o;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  orbr_useq #(.AW(AW), .CW(CW), .CS_INIT(CS_IMG)) u_dut (
    .clk(clk), .rst(rst), .status(status), .ctrl_o(ctrl_o), .uaddr_o(uaddr_o)
  );

  task automatic check(input string req, input logic [AW-1:0] ea, input logic [CW-1:0] ec);
    checks++;
    if (uaddr_o !== ea || ctrl_o !== ec) begin
      fails++;
      $display("FAIL %s: addr=%0d ctrl=%h expected addr=%0d ctrl=%h", req, uaddr_o, ctrl_o, ea, ec);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog: addr=%0d expected run to end", uaddr_o);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", '0, '0);
    rst = 1'b0;
    // R2 first word, R3 control field, R4..R9 dispatch walk
    for (int i = 0; i < NV; i++) begin
      status = VST[i];
      @(negedge clk);
      check($sformatf("R2-walk R9 step %0d (R4 R5 R6 R7 R8)", i), VEA[i], ctrl_of(int'(VEA[i])));
    end
    status = 8'h00;
    @(negedge clk);
    check("R9 next cycle", 6'd1, ctrl_of(1));
    rst = 1'b1;
    status = 8'hFF;
    @(negedge clk);
    check("R1 midrun reset", '0, '0);
    @(negedge clk);
    check("R1 reset held", '0, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R2 restart at 0", 6'd0, ctrl_of(0));
    @(negedge clk);
    check("R4 status ignored", 6'd1, ctrl_of(1));
    @(negedge clk);
    check("R6 four-way all ones", 6'd7, ctrl_of(7));
    @(negedge clk);
    check("R3 after dispatch", 6'd8, ctrl_of(8));
    finish_run();
  end
endmodule